// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the combinational arithmetic-logic unit of a 16-bit accumulator machine. On each evaluation it reads the current accumulator value, a second operand and a 6-bit opcode. It returns a 16-bit result and four status flags: carry, overflow, sign and zero. The surrounding datapath writes the result back into the accumulator and keeps the flags. Register storage and instruction sequencing belong to the datapath, not to this block.

The second operand comes either from a full-width memory word or from a 10-bit immediate field. A select input picks the source. The immediate field is sign-extended to 16 bits before any operation uses it.

There are three groups of operations:
- Binary arithmetic: add and subtract.
- Bitwise logic: AND and OR.
- Unary operations on the accumulator alone: complement, single-bit shifts, increment and decrement.

All arithmetic shares one adder. Unsigned carry or borrow and signed overflow both come from that single addition.

Top module: `acc_alu`

## Requirements
- R1: Opcodes are decoded as 0x00 add, 0x01 subtract, 0x02 AND, 0x03 OR, 0x04 complement, 0x05 shift left, 0x06 shift right, 0x07 increment, 0x08 decrement.
- R2: Add returns (acc + operand) mod 2^16. Carry is the unsigned carry-out. Overflow is set when the signed sum lies outside -32768..32767.
- R3: Subtract returns (acc - operand) mod 2^16. Carry is set when acc < operand as unsigned numbers (borrow). Overflow is set when the signed difference lies outside -32768..32767.
- R4: AND and OR return the bitwise AND or OR of acc and operand, with carry and overflow cleared.
- R5: Complement returns the bitwise inverse of acc, with carry and overflow cleared.
- R6: Shift left returns acc shifted up one bit with bit 0 filled with 0. Carry takes acc bit 15 and overflow is cleared.
- R7: Shift right is logical: it returns acc shifted down one bit with bit 15 filled with 0. Carry takes acc bit 0 and overflow is cleared.
- R8: Increment returns acc + 1, with carry set only when acc = 0xFFFF and overflow set only when acc = 0x7FFF. Decrement returns acc - 1, with carry (borrow) set only when acc = 0x0000 and overflow set only when acc = 0x8000.
- R9: The sign flag equals bit 15 of the result for every opcode.
- R10: The zero flag is set exactly when all 16 result bits are 0.
- R11: When use_imm is 1, the operand is imm_opd[9:0] sign-extended to 16 bits and mem_opd has no effect. When use_imm is 0, the operand is mem_opd and imm_opd has no effect.
- R12: Any opcode from 0x09 to 0x3F returns acc unchanged, with carry and overflow cleared.
- R13: Complement, both shifts, increment and decrement give the same outputs whatever the operand value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_in | input | 16 | Current accumulator value |
| mem_opd | input | 16 | Operand word read from memory |
| imm_opd | input | 10 | Immediate operand field, two's complement |
| use_imm | input | 1 | 1 selects the sign-extended immediate as the operand |
| opcode | input | 6 | Operation code |
| result | output | 16 | Operation result |
| flag_c | output | 1 | Carry-out, borrow, or bit shifted out |
| flag_v | output | 1 | Signed overflow |
| flag_n | output | 1 | Sign of the result |
| flag_z | output | 1 | Result is zero |

## Verification
Every one of the 64 opcodes is applied to every pairing of sixteen operand values. The values are:
- Zero, one and two.
- The signed extremes and their neighbours.
- All ones.
- Alternating-bit patterns.
- Half-word masks.

This grid makes each carry, borrow and overflow boundary occur on both sides. It separates a logical right shift from an arithmetic one. It also shows whether a unary operation leaks the operand.

While the memory path is in use, the immediate input carries unrelated data, and the reverse holds when the immediate path is in use. A sweep then drives all 1024 immediate values through add against two accumulator values. This sweep shows sign extension for both signs and confirms that the memory word is ignored.

// File: rtl/acc_alu_pkg.sv
// Package: acc_alu_pkg
// Shared opcode encoding and internal selector types for the accumulator ALU.
// Assumes a 6-bit opcode field; values outside the listed set are pass-through.
package acc_alu_pkg;

    localparam int OPC_W = 6;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD = 6'd0,
        OPC_SUB = 6'd1,
        OPC_AND = 6'd2,
        OPC_OR  = 6'd3,
        OPC_NOT = 6'd4,
        OPC_SHL = 6'd5,
        OPC_SHR = 6'd6,
        OPC_INC = 6'd7,
        OPC_DEC = 6'd8
    } opc_e;

    // Which functional unit drives the result.
    typedef enum logic [1:0] {
        SEL_ARITH = 2'd0,
        SEL_LOGIC = 2'd1,
        SEL_SHIFT = 2'd2,
        SEL_PASS  = 2'd3
    } res_sel_e;

    // Bitwise unit operation.
    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_NOT = 2'd2
    } logic_op_e;

endpackage

// File: rtl/acc_alu_opnd_sel.sv
// Module: acc_alu_opnd_sel
// Picks the second ALU operand: the full-width memory word, or the immediate
// field sign-extended to DATA_W. Assumes IMM_W <= DATA_W.
module acc_alu_opnd_sel #(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 10
) (
    input  logic [DATA_W-1:0] mem_opd,
    input  logic [IMM_W-1:0]  imm_opd,
    input  logic              use_imm,
    output logic [DATA_W-1:0] opd
);

    logic [DATA_W-1:0] imm_ext;

    // Widen the immediate by replicating its sign bit when it is narrower.
    generate
        if (IMM_W < DATA_W) begin : g_sext
            localparam int PAD_W = DATA_W - IMM_W;
            assign imm_ext = {{PAD_W{imm_opd[IMM_W-1]}}, imm_opd};
        end else begin : g_full
            assign imm_ext = imm_opd[DATA_W-1:0];
        end
    endgenerate

    // Select the operand source.
    always_comb begin
        opd = use_imm ? imm_ext : mem_opd;
    end

endmodule

// File: rtl/acc_alu_addsub.sv
// Module: acc_alu_addsub
// One shared adder for add, subtract, increment and decrement.
// Subtraction is a + ~b + 1. For subtraction the carry output is the borrow.
// Overflow is derived from the sign of a, the effective b and the sum.
module acc_alu_addsub #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              cy,
    output logic              ovf
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;

    // Form the adder input and the full-width sum with carry-out.
    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
        sum   = wide[MSB:0];
    end

    // Carry/borrow and signed overflow from the single addition.
    always_comb begin
        cy  = sub ? ~wide[DATA_W] : wide[DATA_W];
        ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end

endmodule

// File: rtl/acc_alu_logic.sv
// Module: acc_alu_logic
// Bitwise unit: AND and OR of the two inputs, or the inverse of a alone.
// Assumes op holds one of the three defined codes; any other code returns a.
module acc_alu_logic #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]     a,
    input  logic [DATA_W-1:0]     b,
    input  acc_alu_pkg::logic_op_e op,
    output logic [DATA_W-1:0]     y
);
    import acc_alu_pkg::*;

    // Bitwise function select.
    always_comb begin
        case (op)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_NOT:  y = ~a;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/acc_alu_shift.sv
// Module: acc_alu_shift
// Single-position logical shifter. The vacated bit is zero and the bit that
// falls off the end is returned separately.
module acc_alu_shift #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic              right,
    output logic [DATA_W-1:0] y,
    output logic              out_bit
);

    localparam int MSB = DATA_W - 1;

    // Shift by one and capture the ejected bit.
    always_comb begin
        if (right) begin
            y       = {1'b0, a[MSB:1]};
            out_bit = a[0];
        end else begin
            y       = {a[MSB-1:0], 1'b0};
            out_bit = a[MSB];
        end
    end

endmodule

// File: rtl/acc_alu.sv
// Module: acc_alu (top)
// Combinational accumulator ALU. It decodes the opcode, steers the operands
// into the arithmetic, bitwise or shift unit, and forms carry, overflow,
// sign and zero. It holds no state, so it needs no clock or reset.
// Unlisted opcodes pass the accumulator through.
module acc_alu #(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 10
) (
    input  logic [DATA_W-1:0]             acc_in,
    input  logic [DATA_W-1:0]             mem_opd,
    input  logic [IMM_W-1:0]              imm_opd,
    input  logic                          use_imm,
    input  logic [acc_alu_pkg::OPC_W-1:0] opcode,
    output logic [DATA_W-1:0]             result,
    output logic                          flag_c,
    output logic                          flag_v,
    output logic                          flag_n,
    output logic                          flag_z
);
    import acc_alu_pkg::*;

    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] opd;
    logic [DATA_W-1:0] ar_b;
    logic              ar_sub;
    logic [DATA_W-1:0] ar_sum;
    logic              ar_cy;
    logic              ar_ovf;
    logic_op_e         lg_op;
    logic [DATA_W-1:0] lg_y;
    logic              sh_right;
    logic [DATA_W-1:0] sh_y;
    logic              sh_out;
    res_sel_e          sel;

    acc_alu_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
        .mem_opd (mem_opd),
        .imm_opd (imm_opd),
        .use_imm (use_imm),
        .opd     (opd)
    );

    acc_alu_addsub #(.DATA_W(DATA_W)) u_arith (
        .a   (acc_in),
        .b   (ar_b),
        .sub (ar_sub),
        .sum (ar_sum),
        .cy  (ar_cy),
        .ovf (ar_ovf)
    );

    acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a  (acc_in),
        .b  (opd),
        .op (lg_op),
        .y  (lg_y)
    );

    acc_alu_shift #(.DATA_W(DATA_W)) u_shift (
        .a       (acc_in),
        .right   (sh_right),
        .y       (sh_y),
        .out_bit (sh_out)
    );

    // Decode the opcode into unit controls and a result select.
    always_comb begin
        sel      = SEL_PASS;
        ar_b     = opd;
        ar_sub   = 1'b0;
        lg_op    = LG_AND;
        sh_right = 1'b0;
        case (opcode)
            OPC_ADD: sel = SEL_ARITH;
            OPC_SUB: begin sel = SEL_ARITH; ar_sub = 1'b1; end
            OPC_AND: sel = SEL_LOGIC;
            OPC_OR:  begin sel = SEL_LOGIC; lg_op = LG_OR; end
            OPC_NOT: begin sel = SEL_LOGIC; lg_op = LG_NOT; end
            OPC_SHL: sel = SEL_SHIFT;
            OPC_SHR: begin sel = SEL_SHIFT; sh_right = 1'b1; end
            OPC_INC: begin sel = SEL_ARITH; ar_b = ONE; end
            OPC_DEC: begin sel = SEL_ARITH; ar_b = ONE; ar_sub = 1'b1; end
            default: sel = SEL_PASS;
        endcase
    end

    // Steer the chosen unit to the result and the carry/overflow flags.
    always_comb begin
        case (sel)
            SEL_ARITH: begin result = ar_sum; flag_c = ar_cy;  flag_v = ar_ovf; end
            SEL_LOGIC: begin result = lg_y;   flag_c = 1'b0;   flag_v = 1'b0;   end
            SEL_SHIFT: begin result = sh_y;   flag_c = sh_out; flag_v = 1'b0;   end
            default:   begin result = acc_in; flag_c = 1'b0;   flag_v = 1'b0;   end
        endcase
    end

    // Sign and zero follow from the final result.
    always_comb begin
        flag_n = result[MSB];
        flag_z = (result == '0);
    end

    // Cross-unit checks on the assembled outputs.
    always_comb begin
        if (opcode == OPC_ADD) begin
            // R2
            add_sum_chk: assert ({flag_c, result} == ({1'b0, acc_in} + {1'b0, opd}))
                else $error("add result/carry mismatch");
            // R2
            add_ovf_chk: assert (flag_v == ((acc_in[MSB] == opd[MSB]) && (result[MSB] != acc_in[MSB])))
                else $error("add overflow mismatch");
        end
        if (opcode == OPC_SUB) begin
            // R3
            sub_borrow_chk: assert ((flag_c == (acc_in < opd)) && (result == acc_in - opd))
                else $error("subtract result/borrow mismatch");
        end
        if (opcode == OPC_NOT) begin
            // R5
            not_cpl_chk: assert (((result ^ acc_in) == '1) && !flag_c && !flag_v)
                else $error("complement mismatch");
        end
        if (opcode == OPC_SHL) begin
            // R6
            shl_out_chk: assert ({flag_c, result} == {acc_in, 1'b0})
                else $error("shift left mismatch");
        end
        if (opcode > OPC_DEC) begin
            // R12
            pass_thru_chk: assert ((result == acc_in) && !flag_c && !flag_v)
                else $error("unlisted opcode changed state");
        end
    end

endmodule

// File: tb/tb_acc_alu.sv
// Bench for acc_alu: an opcode x operand-grid sweep, an immediate sweep,
// and an arithmetic reference model.
module tb_acc_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] acc_in = '0;
    logic [15:0] mem_opd = '0;
    logic [9:0]  imm_opd = '0;
    logic        use_imm = 1'b0;
    logic [5:0]  opcode = '0;
    logic [15:0] result;
    logic        flag_c, flag_v, flag_n, flag_z;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    acc_alu dut (
        .acc_in  (acc_in),
        .mem_opd (mem_opd),
        .imm_opd (imm_opd),
        .use_imm (use_imm),
        .opcode  (opcode),
        .result  (result),
        .flag_c  (flag_c),
        .flag_v  (flag_v),
        .flag_n  (flag_n),
        .flag_z  (flag_z)
    );

    function automatic logic [15:0] grid(input int i);
        case (i)
            0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;
            3: return 16'h7FFF;  4: return 16'h8000;  5: return 16'h8001;
            6: return 16'hFFFF;  7: return 16'hFFFE;  8: return 16'h5555;
            9: return 16'hAAAA; 10: return 16'h00FF; 11: return 16'hFF00;
            12: return 16'h1234; 13: return 16'hEDCB; 14: return 16'h4000;
            default: return 16'hC000;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] op);
        case (op)
            6'd0: return "R1 R2";
            6'd1: return "R1 R3";
            6'd2, 6'd3: return "R1 R4";
            6'd4: return "R1 R5 R13";
            6'd5: return "R1 R6 R13";
            6'd6: return "R1 R7 R13";
            6'd7, 6'd8: return "R1 R8 R13";
            default: return "R12";
        endcase
    endfunction

    // Reference model computed from the requirements with wide integers.
    task automatic model(input logic [5:0] op, input logic [15:0] a, input logic [15:0] b,
                         output logic [15:0] r, output logic c, output logic v);
        int sa, sb, sr;
        logic [16:0] w;
        sa = int'($signed(a));
        sb = int'($signed(b));
        r = a; c = 1'b0; v = 1'b0;
        case (op)
            6'd0: begin w = {1'b0, a} + {1'b0, b}; r = w[15:0]; c = w[16];
                        sr = sa + sb; v = (sr > 32767) || (sr < -32768); end
            6'd1: begin r = a - b; c = (a < b);
                        sr = sa - sb; v = (sr > 32767) || (sr < -32768); end
            6'd2: r = a & b;
            6'd3: r = a | b;
            6'd4: r = ~a;
            6'd5: begin r = {a[14:0], 1'b0}; c = a[15]; end
            6'd6: begin r = {1'b0, a[15:1]}; c = a[0]; end
            6'd7: begin r = a + 16'd1; c = (a == 16'hFFFF); v = (a == 16'h7FFF); end
            6'd8: begin r = a - 16'd1; c = (a == 16'h0000); v = (a == 16'h8000); end
            default: ;
        endcase
    endtask

    task automatic check(input string tag, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s op=%0h acc=%h opd_mem=%h imm=%h sel=%0b actual=%h expected=%h",
                     tag, what, opcode, acc_in, mem_opd, imm_opd, use_imm, got, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic [15:0] er, input logic ec,
                             input logic ev);
        check(tag, "result", 32'(result), 32'(er));
        check(tag, "carry", 32'(flag_c), 32'(ec));
        check(tag, "ovf", 32'(flag_v), 32'(ev));
        check("R9", "sign", 32'(flag_n), 32'(er[15]));
        check("R10", "zero", 32'(flag_z), 32'(er == 16'h0000));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-R actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] er;
        logic ec, ev;
        // Reset window: all inputs zero, opcode add.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", "idle zero", 32'(flag_z), 32'd1);
        check("R2", "idle result", 32'(result), 32'd0);
        check("R2", "idle carry", 32'(flag_c), 32'd0);
        rst_n = 1'b1;

        // Grid sweep over all opcodes with the memory operand; imm carries junk (R11).
        for (int op = 0; op < 64; op++) begin
            for (int ai = 0; ai < 16; ai++) begin
                for (int bi = 0; bi < 16; bi++) begin
                    @(posedge clk);
                    opcode  = 6'(op);
                    acc_in  = grid(ai);
                    mem_opd = grid(bi);
                    imm_opd = ~grid(bi + 3)[9:0];
                    use_imm = 1'b0;
                    @(negedge clk);
                    model(6'(op), grid(ai), grid(bi), er, ec, ev);
                    check_all(tag_of(6'(op)), er, ec, ev);
                end
            end
        end

        // Immediate sweep: sign-extended imm with add; memory word is junk (R11).
        for (int ai = 0; ai < 2; ai++) begin
            for (int iv = 0; iv < 1024; iv++) begin
                logic [15:0] ext;
                @(posedge clk);
                opcode  = 6'd0;
                acc_in  = (ai == 0) ? 16'h0000 : 16'h7FF0;
                imm_opd = 10'(iv);
                mem_opd = 16'hA5C3 ^ 16'(iv);
                use_imm = 1'b1;
                @(negedge clk);
                ext = {{6{imm_opd[9]}}, imm_opd};
                model(6'd0, acc_in, ext, er, ec, ev);
                check_all("R11", er, ec, ev);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule